// File: doc/BRIEF.md
# Memory-Mapped Multiply-Accumulate Peripheral

This block is a 16-bit hardware multiplier that sits on a simple processor peripheral bus. The bus has a word address, a write strobe, write data and combinational read data. Software chooses the operation through the address it uses for the first operand. There are four first-operand addresses: unsigned multiply, signed multiply, unsigned multiply-accumulate and signed multiply-accumulate. Writing the second operand runs the selected operation in that same clock edge. The 32-bit result then sits in a pair of result registers.

Software can write the result pair directly, so it also serves as the accumulator and can be preloaded before an accumulate operation. A read-only extension register reports the carry out of an unsigned accumulation, or the sign of a signed result. The selected mode stays in force until the next first-operand write. Repeated second-operand writes therefore reuse the same first operand and mode.

Top module: `mulacc_periph`

## Requirements
- R1: After reset, every mapped register reads 0x0000: the operand, the result halves and the extension.
- R2: The byte-address offsets from the base (0x0130) are as follows. +0x0 is the unsigned-multiply first operand, +0x2 the signed-multiply first operand, +0x4 the unsigned-accumulate first operand, +0x6 the signed-accumulate first operand, +0x8 the second operand, +0xA the result low half, +0xC the result high half and +0xE the extension. A read from any of the four first-operand offsets returns the latched first operand. A read from +0x8 returns the last second operand.
- R3: The result and extension values produced by a second-operand write can be read in the very next cycle.
- R4: Unsigned multiply replaces the result pair with the 32-bit unsigned product, discarding the earlier contents. The extension reads 0x0000.
- R5: Signed multiply treats both operands as two's complement and replaces the result pair with the 32-bit product. The extension reads 0xFFFF when result bit 31 is set and 0x0000 otherwise.
- R6: Unsigned accumulate adds the unsigned product to the result pair modulo 2^32. The extension reads 0x0001 when that 32-bit addition carries out and 0x0000 otherwise.
- R7: Signed accumulate adds the sign-extended two's complement product to the result pair modulo 2^32. The extension reads 0xFFFF when result bit 31 is set and 0x0000 otherwise.
- R8: Writes to the result-low and result-high offsets load those halves directly. A write to the extension offset leaves it unchanged.
- R9: A read from an unmapped address, including an odd address inside the window, returns 0x0000. A write to an unmapped address changes no register.
- R10: The mode and first operand persist across second-operand writes until the next first-operand write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Byte address of the access |
| busWr | input | 1 | Write strobe, sampled on the rising clock edge |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for busAddr, combinational |

## Verification
Every internal register can be read back through the bus. As a result, a wrong mode bit, a stale first operand or a lost carry shows up on busRdData no later than the first read that follows the second-operand write. A wrong mode latch changes the signed or accumulate behaviour of the next result, and the extension register exposes it at once. A missed carry or sign-extension error shows up in the extension or the high half after an accumulate from a preloaded value such as 0xC000_0000. The sweep includes operand pairs that force the 32-bit sum to wrap.

// File: rtl/mulacc_pkg.sv
package mulacc_pkg;

  // Mode encoding equals the first-operand offset index: bit0 = signed, bit1 = accumulate
  typedef enum logic [1:0] {
    MODE_UMPY = 2'd0,
    MODE_SMPY = 2'd1,
    MODE_UMAC = 2'd2,
    MODE_SMAC = 2'd3
  } mulMode_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OP1,
    SEL_OP2,
    SEL_LO,
    SEL_HI,
    SEL_EXT
  } rdSel_t;

  typedef struct packed {
    logic     op1Load;
    logic     op2Start;
    logic     loLoad;
    logic     hiLoad;
    mulMode_t mode;
    rdSel_t   rdSel;
  } mulStrobe_t;

endpackage

// File: rtl/mulacc_ctrl.sv
module mulacc_ctrl
  import mulacc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0130
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output mulStrobe_t        stb
);

  localparam int WIN_LSB = 4;

  logic     winHit;
  logic [2:0] regIdx;
  mulMode_t modeQ;

  assign winHit = (busAddr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]) && !busAddr[0];
  assign regIdx = busAddr[WIN_LSB-1:1];

  always_comb begin
    stb = '0;
    stb.mode  = modeQ;
    stb.rdSel = SEL_NONE;
    if (winHit) begin
      unique case (regIdx)
        3'd0, 3'd1, 3'd2, 3'd3: begin
          stb.rdSel   = SEL_OP1;
          stb.op1Load = busWr;
        end
        3'd4: begin
          stb.rdSel    = SEL_OP2;
          stb.op2Start = busWr;
        end
        3'd5: begin
          stb.rdSel  = SEL_LO;
          stb.loLoad = busWr;
        end
        3'd6: begin
          stb.rdSel  = SEL_HI;
          stb.hiLoad = busWr;
        end
        default: stb.rdSel = SEL_EXT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_UMPY;
    end else if (winHit && busWr && !regIdx[2]) begin
      modeQ <= mulMode_t'(regIdx[1:0]);
    end
  end

endmodule

// File: rtl/mulacc_dp.sv
module mulacc_dp
  import mulacc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mulStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int RES_W  = 2 * DATA_W;
  localparam int WIDE_W = RES_W + 2;

  logic [DATA_W-1:0] op1Q, op2Q, extQ;
  logic [RES_W-1:0]  resQ;

  logic              isSigned, isMac;
  logic [DATA_W:0]   aExt, bExt;
  logic [WIDE_W-1:0] aWide, bWide, prodWide;
  logic [RES_W-1:0]  product, accIn, newRes;
  logic [RES_W:0]    sumWide;
  logic [DATA_W-1:0] newExt;

  // Operand extension: one shared multiplier serves signed and unsigned modes
  always_comb begin
    isSigned = stb.mode[0];
    isMac    = stb.mode[1];
    aExt     = {isSigned & op1Q[DATA_W-1], op1Q};
    bExt     = {isSigned & wrData[DATA_W-1], wrData};
    aWide    = {{(WIDE_W-DATA_W-1){aExt[DATA_W]}}, aExt};
    bWide    = {{(WIDE_W-DATA_W-1){bExt[DATA_W]}}, bExt};
    prodWide = aWide * bWide;
    product  = prodWide[RES_W-1:0];
    accIn    = isMac ? resQ : '0;
    sumWide  = {1'b0, accIn} + {1'b0, product};
    newRes   = sumWide[RES_W-1:0];
    if (isSigned) begin
      newExt = {DATA_W{newRes[RES_W-1]}};
    end else if (isMac) begin
      newExt = {{(DATA_W-1){1'b0}}, sumWide[RES_W]};
    end else begin
      newExt = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      op1Q <= '0;
      op2Q <= '0;
      resQ <= '0;
      extQ <= '0;
    end else begin
      if (stb.op1Load) op1Q <= wrData;
      if (stb.op2Start) begin
        op2Q <= wrData;
        resQ <= newRes;
        extQ <= newExt;
      end
      if (stb.loLoad) resQ[DATA_W-1:0]     <= wrData;
      if (stb.hiLoad) resQ[RES_W-1:DATA_W] <= wrData;
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      SEL_OP1: rdData = op1Q;
      SEL_OP2: rdData = op2Q;
      SEL_LO:  rdData = resQ[DATA_W-1:0];
      SEL_HI:  rdData = resQ[RES_W-1:DATA_W];
      SEL_EXT: rdData = extQ;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/mulacc_periph.sv
module mulacc_periph
  import mulacc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0130
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData
);

  mulStrobe_t stb;

  mulacc_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWr   (busWr),
    .stb     (stb)
  );

  mulacc_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (busWrData),
    .rdData (busRdData)
  );

endmodule

// File: rtl/mulacc_checker.sv
module mulacc_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0130
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData
);

  localparam logic [ADDR_W-1:0] A_OP1U = BASE_ADDR;
  localparam logic [ADDR_W-1:0] A_OP1S = BASE_ADDR + ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_OP2  = BASE_ADDR + ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_LO   = BASE_ADDR + ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_EXT  = BASE_ADDR + ADDR_W'(14);
  localparam logic [ADDR_W-1:0] A_END  = BASE_ADDR + ADDR_W'(16);

  logic isOp1, inWin;
  logic [1:0] shMode;

  assign isOp1 = (busAddr >= A_OP1U) && (busAddr <= A_OP1S) && !busAddr[0];
  assign inWin = (busAddr >= BASE_ADDR) && (busAddr < A_END) && !busAddr[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shMode <= 2'd0;
    else if (busWr && isOp1) shMode <= busAddr[2:1];
  end

  // R9: unmapped addresses read zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    !inWin |-> busRdData == '0);

  // R8: extension ignores writes
  a_r8_ext_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busWr && busAddr == A_EXT) && busAddr == A_EXT) |-> busRdData == $past(busRdData));

  // R8: result-low preload is visible on the next cycle
  a_r8_preload_lo: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busWr && busAddr == A_LO) && busAddr == A_LO) |-> busRdData == $past(busWrData));

  // R2: first operand reads back from any first-operand offset
  a_r2_op1_readback: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busWr && isOp1) && isOp1) |-> busRdData == $past(busWrData));

  // R4: unsigned multiply leaves extension at zero
  a_r4_umpy_ext_zero: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busWr && busAddr == A_OP2 && shMode == 2'd0) && busAddr == A_EXT) |-> busRdData == '0);

  // R6: extension only ever holds 0x0000, 0x0001 or all ones
  a_r6_ext_range: assert property (@(posedge clk) disable iff (!rstN)
    busAddr == A_EXT |-> (busRdData == '0 || busRdData == DATA_W'(1) || busRdData == '1));

endmodule

bind mulacc_periph mulacc_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWr     (busWr),
  .busWrData (busWrData),
  .busRdData (busRdData)
);

// File: tb/mulacc_periph_bench.sv
module mulacc_periph_bench;

  localparam logic [15:0] B      = 16'h0130;
  localparam logic [15:0] A_UMPY = B + 16'h0;
  localparam logic [15:0] A_SMPY = B + 16'h2;
  localparam logic [15:0] A_UMAC = B + 16'h4;
  localparam logic [15:0] A_SMAC = B + 16'h6;
  localparam logic [15:0] A_OP2  = B + 16'h8;
  localparam logic [15:0] A_LO   = B + 16'hA;
  localparam logic [15:0] A_HI   = B + 16'hC;
  localparam logic [15:0] A_EXT  = B + 16'hE;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic busWr = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic rdReq = 1'b0;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [15:0] addr;
    logic [15:0] expVal;
    string       tag;
  } item_t;
  item_t sbQ[$];

  // Reference state kept from the requirements
  logic [1:0]  mMode = 2'd0;
  logic [15:0] mOp1 = '0, mOp2 = '0, mLo = '0, mHi = '0, mExt = '0;

  always #4 clk = ~clk;

  mulacc_periph u_mulacc_periph (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busWrData (busWrData),
    .busRdData (busRdData)
  );

  function automatic logic [15:0] modelRead(input logic [15:0] a);
    if (a == A_UMPY || a == A_SMPY || a == A_UMAC || a == A_SMAC) return mOp1;
    if (a == A_OP2) return mOp2;
    if (a == A_LO)  return mLo;
    if (a == A_HI)  return mHi;
    if (a == A_EXT) return mExt;
    return 16'h0000;
  endfunction

  task automatic modelWrite(input logic [15:0] a, input logic [15:0] d);
    longint opA, opB, prod, accV, sumV;
    logic [31:0] acc32, res32;
    if (a == A_UMPY || a == A_SMPY || a == A_UMAC || a == A_SMAC) begin
      mOp1  = d;
      mMode = 2'((a - B) >> 1);
    end else if (a == A_OP2) begin
      mOp2  = d;
      opA   = mMode[0] ? longint'($signed(mOp1)) : longint'(mOp1);
      opB   = mMode[0] ? longint'($signed(d))    : longint'(d);
      prod  = opA * opB;
      acc32 = {mHi, mLo};
      accV  = mMode[0] ? longint'($signed(acc32)) : longint'(acc32);
      sumV  = mMode[1] ? prod + accV : prod;
      res32 = sumV[31:0];
      {mHi, mLo} = res32;
      if (mMode[0])      mExt = res32[31] ? 16'hFFFF : 16'h0000;
      else if (mMode[1]) mExt = {15'd0, sumV[32]};
      else               mExt = 16'h0000;
    end else if (a == A_LO) begin
      mLo = d;
    end else if (a == A_HI) begin
      mHi = d;
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    rdReq = 1'b0; busAddr = a; busWr = 1'b1; busWrData = d;
    modelWrite(a, d);
  endtask

  task automatic busRead(input logic [15:0] a, input string tag);
    item_t it;
    @(posedge clk); #1;
    busWr = 1'b0; busAddr = a; rdReq = 1'b1;
    it.addr = a; it.expVal = modelRead(a); it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    busWr = 1'b0; rdReq = 1'b0;
  endtask

  // Monitor: pops one expected item per read cycle
  always @(negedge clk) begin
    if (rdReq && sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      checks++;
      if (busRdData !== it.expVal) begin
        fails++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, busRdData, it.expVal);
      end
    end
  end

  task automatic readResult(input string tag);
    busRead(A_LO, tag);
    busRead(A_HI, tag);
    busRead(A_EXT, tag);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    report();
  end

  initial begin
    logic [15:0] vals [6];
    vals = '{16'h0000, 16'h0010, 16'h00F0, 16'h1000, 16'hF000, 16'hF0F0};
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state of every register
    busRead(A_UMPY, "R1"); busRead(A_OP2, "R1");
    readResult("R1");

    // R2: map and readback of operands
    busWrite(A_SMAC, 16'h1234);
    busRead(A_UMPY, "R2"); busRead(A_SMPY, "R2"); busRead(A_UMAC, "R2"); busRead(A_SMAC, "R2");
    busWrite(A_OP2, 16'h0002);
    busRead(A_OP2, "R2");

    // R9: unmapped accesses
    busWrite(16'h0140, 16'hBEEF);
    busWrite(16'h0131, 16'hBEEF);
    busWrite(16'h013B, 16'hBEEF);
    busRead(16'h0140, "R9"); busRead(16'h0131, "R9"); busRead(16'h0000, "R9");
    busRead(A_UMPY, "R9"); busRead(A_OP2, "R9");
    readResult("R9");

    // R6 and R3: unsigned accumulate sweep with preload 0xC000_0000
    foreach (vals[i]) begin
      foreach (vals[j]) begin
        busWrite(A_LO, 16'h0000);
        busWrite(A_HI, 16'hC000);
        busWrite(A_UMAC, vals[i]);
        busWrite(A_OP2, vals[j]);
        readResult("R6_R3");
      end
    end
    // R6: carry out forced
    busWrite(A_LO, 16'hFFFF); busWrite(A_HI, 16'hFFFF);
    busWrite(A_UMAC, 16'h0001); busWrite(A_OP2, 16'h0001);
    readResult("R6");

    // R4: unsigned multiply overwrites preload
    busWrite(A_LO, 16'h5555); busWrite(A_HI, 16'hAAAA);
    busWrite(A_UMPY, 16'hF0F0); busWrite(A_OP2, 16'hF0F0);
    readResult("R4");
    busWrite(A_UMPY, 16'hFFFF); busWrite(A_OP2, 16'hFFFF);
    readResult("R4");

    // R5: signed multiply
    busWrite(A_SMPY, 16'hFFFD); busWrite(A_OP2, 16'h0005);
    readResult("R5");
    busWrite(A_SMPY, 16'h8000); busWrite(A_OP2, 16'h8000);
    readResult("R5");
    busWrite(A_SMPY, 16'h0007); busWrite(A_OP2, 16'h0009);
    readResult("R5");

    // R7: signed accumulate
    busWrite(A_LO, 16'h0005); busWrite(A_HI, 16'h0000);
    busWrite(A_SMAC, 16'hFFFD); busWrite(A_OP2, 16'h0004);
    readResult("R7");
    busWrite(A_LO, 16'hFFFF); busWrite(A_HI, 16'hFFFF);
    busWrite(A_SMAC, 16'h0001); busWrite(A_OP2, 16'h0001);
    readResult("R7");

    // R8: preload readback and extension write ignored
    busWrite(A_SMPY, 16'hFFFF); busWrite(A_OP2, 16'h0001);
    busWrite(A_EXT, 16'h1234);
    busRead(A_EXT, "R8");
    busWrite(A_LO, 16'hA5A5); busRead(A_LO, "R8");
    busWrite(A_HI, 16'h5A5A); busRead(A_HI, "R8");

    // R10: mode and operand persist across second-operand writes
    busWrite(A_LO, 16'h0000); busWrite(A_HI, 16'h0000);
    busWrite(A_UMAC, 16'h0003);
    busWrite(A_OP2, 16'h0004);
    busWrite(A_OP2, 16'h0004);
    readResult("R10");
    busWrite(A_SMPY, 16'hFFFE);
    busWrite(A_OP2, 16'h0003);
    busWrite(A_OP2, 16'h0005);
    readResult("R10");

    idle();
    idle();
    if (sbQ.size() != 0) begin
      fails++;
      $display("FAIL R3 pending=%0d expected=0", sbQ.size());
    end
    report();
  end

endmodule